// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

The monitor checks that two independent clocks keep the expected frequency ratio. A measuring counter in the bus-clock domain advances once every `PRESCALE` bus cycles. A free-running divider in the reference-clock domain produces a trigger once every `REF_DIV * TRIG_MOD` reference cycles. The trigger crosses into the bus domain and causes two things in hardware, with no software step: the counter value is latched into a capture register, and the counter restarts from zero. Each capture is therefore a direct ratio measurement.

Every capture is compared against two programmable inclusive bounds. A result bit reports the latest verdict, and a sticky fail flag keeps any failure until reset. If the reference trigger stops, the counter saturates and a missing-trigger flag is raised. A change of both clocks by the same relative amount leaves every capture unchanged. The monitor cannot see such a fault.

Top module: `clk_ratio_mon`

## Requirements
- R1: After reset, captureValue, captureValid, result, failSticky and missingTrigger are all 0.
- R2: The counter advances once per PRESCALE bus cycles. A capture equals (bus cycles between triggers - 1) / PRESCALE, rounded down, within 2 counts.
- R3: Reference triggers occur every REF_DIV*TRIG_MOD reference cycles. Consecutive captures are spaced by that time expressed in bus cycles, within 2 cycles.
- R4: captureValid is high for exactly one bus cycle per capture. The counter restarts from zero at each trigger.
- R5: The first trigger after enable rises produces no captureValid pulse. It only restarts the counter.
- R6: result is 1 when the captured value is above upperBound or below lowerBound, and 0 otherwise. Both bounds are inclusive.
- R7: failSticky goes to 1 on any failed capture or saturation, and stays 1 until reset.
- R8: When no trigger arrives, the counter stops at 2^CNT_W-1, and missingTrigger and failSticky become 1.
- R9: Scaling both clock periods by the same factor leaves the captured value unchanged.
- R10: While enable is 0, no capture happens and the counter is held at zero, so it never saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock, measured side |
| busRstN | input | 1 | Active-low reset, bus domain |
| refClk | input | 1 | Slow reference clock |
| refRstN | input | 1 | Active-low reset, reference domain |
| enable | input | 1 | Starts the measurement; low holds the counter at zero |
| lowerBound | input | CNT_W | Lowest acceptable capture (inclusive) |
| upperBound | input | CNT_W | Highest acceptable capture (inclusive) |
| captureValue | output | CNT_W | Last captured ratio |
| captureValid | output | 1 | One-cycle pulse on each new capture |
| result | output | 1 | 0 pass, 1 out of range, for the last capture |
| failSticky | output | 1 | Any failure since reset |
| missingTrigger | output | 1 | The counter saturated for lack of a trigger |

## Verification
Saturation is the hardest case to reach from the ports, because the trigger normally arrives long before the counter fills. The bench uses a narrow counter and doubles the reference period, so that the counter runs into its ceiling before the next trigger. Common drift is reached by stretching both bench clock periods by the same factor after a reset. The discarded first capture is observed by counting captureValid pulses inside a window shorter than one trigger period after enable.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic hold;     // measurement disabled: keep counter at zero
    logic restart;  // trigger seen: counter back to zero
    logic capture;  // trigger seen while armed: latch counter
  } ratioCtl_t;
endpackage

// File: rtl/clk_ratio_refgen.sv
module clk_ratio_refgen #(
  parameter int REF_DIV  = 4,
  parameter int TRIG_MOD = 5000
) (
  input  logic refClk,
  input  logic refRstN,
  output logic trigToggle
);
  localparam int DIV_W = $clog2(REF_DIV > 1 ? REF_DIV : 2);
  localparam int MOD_W = $clog2(TRIG_MOD > 1 ? TRIG_MOD : 2);

  logic [DIV_W-1:0] divCnt;
  logic [MOD_W-1:0] modCnt;

  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN) begin
      divCnt     <= '0;
      modCnt     <= '0;
      trigToggle <= 1'b0;
    end else if (divCnt == DIV_W'(REF_DIV - 1)) begin
      divCnt <= '0;
      if (modCnt == MOD_W'(TRIG_MOD - 1)) begin
        modCnt     <= '0;
        trigToggle <= ~trigToggle;
      end else begin
        modCnt <= modCnt + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      busClk,
  input  logic      busRstN,
  input  logic      enable,
  input  logic      trigToggle,
  output ratioCtl_t ctl
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   trigLast;
  logic                   armed;
  logic                   trigEdge;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      syncChain <= '0;
      trigLast  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], trigToggle};
      trigLast  <= syncChain[SYNC_STAGES-1];
    end
  end

  assign trigEdge = syncChain[SYNC_STAGES-1] ^ trigLast;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)      armed <= 1'b0;
    else if (!enable)  armed <= 1'b0;
    else if (trigEdge) armed <= 1'b1;
  end

  always_comb begin
    ctl.hold    = !enable;
    ctl.restart = enable && trigEdge;
    ctl.capture = enable && trigEdge && armed;
  end
endmodule

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 128
) (
  input  logic             busClk,
  input  logic             busRstN,
  input  ratioCtl_t        ctl,
  input  logic [CNT_W-1:0] lowerBound,
  input  logic [CNT_W-1:0] upperBound,
  output logic [CNT_W-1:0] captureValue,
  output logic             captureValid,
  output logic             result,
  output logic             failSticky,
  output logic             missingTrigger
);
  localparam int PRE_W = $clog2(PRESCALE > 1 ? PRESCALE : 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] ratioCnt;
  logic             outOfRange;
  logic             saturated;

  assign outOfRange = (ratioCnt > upperBound) || (ratioCnt < lowerBound);
  assign saturated  = !ctl.hold && (ratioCnt == CNT_MAX);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      preCnt   <= '0;
      ratioCnt <= '0;
    end else if (ctl.hold || ctl.restart) begin
      preCnt   <= '0;
      ratioCnt <= '0;
    end else if (preCnt == PRE_W'(PRESCALE - 1)) begin
      preCnt <= '0;
      if (ratioCnt != CNT_MAX) ratioCnt <= ratioCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      captureValue   <= '0;
      captureValid   <= 1'b0;
      result         <= 1'b0;
      failSticky     <= 1'b0;
      missingTrigger <= 1'b0;
    end else begin
      captureValid <= ctl.capture;
      if (ctl.capture) begin
        captureValue <= ratioCnt;
        result       <= outOfRange;
      end
      if ((ctl.capture && outOfRange) || saturated) failSticky <= 1'b1;
      if (saturated) missingTrigger <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 128,
  parameter int REF_DIV     = 4,
  parameter int TRIG_MOD    = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             busClk,
  input  logic             busRstN,
  input  logic             refClk,
  input  logic             refRstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] lowerBound,
  input  logic [CNT_W-1:0] upperBound,
  output logic [CNT_W-1:0] captureValue,
  output logic             captureValid,
  output logic             result,
  output logic             failSticky,
  output logic             missingTrigger
);
  logic      trigToggle;
  ratioCtl_t ctl;

  clk_ratio_refgen #(.REF_DIV(REF_DIV), .TRIG_MOD(TRIG_MOD)) refgen_i (
    .refClk(refClk), .refRstN(refRstN), .trigToggle(trigToggle)
  );

  clk_ratio_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .busClk(busClk), .busRstN(busRstN), .enable(enable),
    .trigToggle(trigToggle), .ctl(ctl)
  );

  clk_ratio_dp #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) dp_i (
    .busClk(busClk), .busRstN(busRstN), .ctl(ctl),
    .lowerBound(lowerBound), .upperBound(upperBound),
    .captureValue(captureValue), .captureValid(captureValid),
    .result(result), .failSticky(failSticky), .missingTrigger(missingTrigger)
  );
endmodule

// File: rtl/clk_ratio_mon_chk.sv
module clk_ratio_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             busClk,
  input logic             busRstN,
  input logic             enable,
  input logic [CNT_W-1:0] lowerBound,
  input logic [CNT_W-1:0] upperBound,
  input logic [CNT_W-1:0] captureValue,
  input logic             captureValid,
  input logic             result,
  input logic             failSticky,
  input logic             missingTrigger
);
  a_r4_single_pulse: assert property (@(posedge busClk) disable iff (!busRstN)
    captureValid |=> !captureValid);

  a_r6_verdict: assert property (@(posedge busClk) disable iff (!busRstN)
    captureValid |-> result == ((captureValue > $past(upperBound)) ||
                                (captureValue < $past(lowerBound))));

  a_r7_sticky: assert property (@(posedge busClk) disable iff (!busRstN)
    failSticky |=> failSticky);

  a_r7_fail_on_bad: assert property (@(posedge busClk) disable iff (!busRstN)
    (captureValid && result) |-> failSticky);

  a_r8_missing_holds: assert property (@(posedge busClk) disable iff (!busRstN)
    missingTrigger |=> missingTrigger);

  a_r8_missing_fails: assert property (@(posedge busClk) disable iff (!busRstN)
    missingTrigger |-> failSticky);

  a_r10_idle: assert property (@(posedge busClk) disable iff (!busRstN)
    !enable |=> !captureValid);

  a_r5_first_skip: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(enable) |=> !captureValid);
endmodule

bind clk_ratio_mon clk_ratio_mon_chk #(.CNT_W(CNT_W)) chk_i (
  .busClk(busClk), .busRstN(busRstN), .enable(enable),
  .lowerBound(lowerBound), .upperBound(upperBound),
  .captureValue(captureValue), .captureValid(captureValid),
  .result(result), .failSticky(failSticky), .missingTrigger(missingTrigger)
);

// File: tb/clk_ratio_mon_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_mon_tb_top;
  localparam int CNT_W = 9, PRESCALE = 4, REF_DIV = 4, TRIG_MOD = 8;
  localparam int SAT   = (1 << CNT_W) - 1;

  real busHalf = 2.5;
  real refHalf = 100.0;
  logic busClk = 0, refClk = 0, busRstN = 0, refRstN = 0, enable = 0;
  logic [CNT_W-1:0] lowerBound = '0, upperBound = '1;
  logic [CNT_W-1:0] captureValue;
  logic captureValid, result, failSticky, missingTrigger;
  int checks = 0, failures = 0, cycles = 0;

  always #(busHalf) busClk = ~busClk;
  always #(refHalf) refClk = ~refClk;

  clk_ratio_mon #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .REF_DIV(REF_DIV),
                  .TRIG_MOD(TRIG_MOD)) dut_i (
    .busClk(busClk), .busRstN(busRstN), .refClk(refClk), .refRstN(refRstN),
    .enable(enable), .lowerBound(lowerBound), .upperBound(upperBound),
    .captureValue(captureValue), .captureValid(captureValid), .result(result),
    .failSticky(failSticky), .missingTrigger(missingTrigger));

  always @(posedge busClk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected capture for given clock half periods (computed from R2/R3)
  function automatic int expCount(real bh, real rh);
    int m;
    m = int'((rh * 2.0 * REF_DIV * TRIG_MOD) / (bh * 2.0));
    return (m - 1) / PRESCALE;
  endfunction

  task automatic restart(input real bh, input real rh);
    enable = 0; busRstN = 0; refRstN = 0;
    busHalf = bh; refHalf = rh;
    #(rh * 4);
    busRstN = 1; refRstN = 1;
    @(negedge busClk);
  endtask

  task automatic waitValid(input int limit, output bit seen, output int n);
    seen = 0;
    for (n = 1; n <= limit; n++) begin
      @(negedge busClk);
      if (captureValid) begin seen = 1; break; end
    end
  endtask

  task automatic t_reset();
    restart(2.5, 100.0);
    chk(captureValue == 0 && !captureValid && !result && !failSticky && !missingTrigger,
        "R1 reset outputs", {captureValue, captureValid, result, failSticky, missingTrigger}, 0);
  endtask

  task automatic t_first_skip_and_period();
    bit seen; int n, cnt, exp;
    restart(2.5, 100.0);
    lowerBound = 300; upperBound = 340;
    enable = 1;
    cnt = 0;
    for (int i = 0; i < 1270; i++) begin
      @(negedge busClk);
      if (captureValid) cnt++;
    end
    chk(cnt == 0, "R5 first trigger discarded", cnt, 0);
    waitValid(3000, seen, n);
    exp = expCount(2.5, 100.0);
    chk(seen && captureValue >= exp - 2 && captureValue <= exp + 2,
        "R2 capture value", captureValue, exp);
    @(negedge busClk);
    chk(!captureValid, "R4 valid one cycle", captureValid, 0);
    waitValid(3000, seen, n);
    n = n + 1;
    chk(seen && n >= 1278 && n <= 1282, "R3 capture spacing", n, 1280);
    chk(!result && !failSticky, "R6 pass in range", result, 0);
  endtask

  task automatic t_bounds();
    bit seen; int n;
    restart(2.5, 100.0);
    lowerBound = 100; upperBound = 310; enable = 1;
    waitValid(3000, seen, n);
    chk(seen && result == 1, "R6 above upper", result, 1);
    chk(failSticky == 1, "R7 sticky set", failSticky, 1);
    lowerBound = 300; upperBound = 340;
    waitValid(3000, seen, n);
    chk(seen && result == 0, "R6 back in range", result, 0);
    chk(failSticky == 1, "R7 sticky held", failSticky, 1);
    restart(2.5, 100.0);
    lowerBound = 330; upperBound = 400; enable = 1;
    waitValid(3000, seen, n);
    chk(seen && result == 1, "R6 below lower", result, 1);
    restart(2.5, 100.0);
    lowerBound = captureValue; upperBound = captureValue;
    lowerBound = 319; upperBound = 319; enable = 1;
    waitValid(3000, seen, n);
    chk(seen && result == (captureValue != 319), "R6 inclusive bounds",
        result, int'(captureValue != 319));
  endtask

  task automatic t_ratio_and_drift();
    bit seen; int n, exp;
    restart(2.5, 50.0);
    lowerBound = 0; upperBound = '1; enable = 1;
    waitValid(3000, seen, n);
    exp = expCount(2.5, 50.0);
    chk(seen && captureValue >= exp - 2 && captureValue <= exp + 2,
        "R2 faster reference", captureValue, exp);
    restart(3.75, 150.0);
    enable = 1;
    waitValid(3000, seen, n);
    exp = expCount(2.5, 100.0);
    chk(seen && captureValue >= exp - 2 && captureValue <= exp + 2,
        "R9 common drift unseen", captureValue, exp);
  endtask

  task automatic t_saturate();
    bit seen; int n;
    restart(2.5, 200.0);
    lowerBound = 0; upperBound = '1; enable = 1;
    waitValid(6000, seen, n);
    chk(seen && captureValue == SAT, "R8 capture saturated", captureValue, SAT);
    chk(missingTrigger && failSticky, "R8 missing flagged",
        {missingTrigger, failSticky}, 3);
  endtask

  task automatic t_disabled();
    int cnt = 0;
    restart(2.5, 200.0);
    for (int i = 0; i < 6000; i++) begin
      @(negedge busClk);
      if (captureValid) cnt++;
    end
    chk(cnt == 0 && captureValue == 0, "R10 no capture when disabled", cnt, 0);
    chk(!missingTrigger && !failSticky, "R10 counter held", missingTrigger, 0);
  endtask

  initial begin
    t_reset();
    t_first_skip_and_period();
    t_bounds();
    t_ratio_and_drift();
    t_saturate();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule